// File: doc/BRIEF.md
# NAND Flash Page Program Command Interface

This block is the device side of a byte-wide NAND-style flash bus. It handles only the page program flow. The host first writes a setup command and five address bytes. It then streams data bytes into a page register, can move the load pointer to other columns, and finally sends a confirm. After a valid confirm the block holds its active-low ready/busy output low for a fixed number of clock cycles. At the end of that interval it merges the page register into a small internal array. The merge can only clear bits. It also records whether every bit that should have cleared did clear.

The host reads a status byte back on the data bus. Status mode starts after a status-read command or after a program starts. It lasts until another command is accepted. One array cell can be marked by parameters as a defective cell whose chosen bits never clear. This gives the failure flag something real to report.

Bus cycles are synchronous. A write strobe that is high for one clock qualifies the bus. With the command latch high, the byte is a command. With the address latch high, the byte is an address. With both latches low, the byte is data. `COLS` and `PAGES` must be powers of two.

Top module: `nand_pgm_if`

## Requirements
- R1: After reset, `rb_n` is 1, the block is idle and outside status mode, and `dout` reads 8'h00.
- R2: Command 8'h80 starts a load and is followed by five address cycles. The low log2(COLS) bits of the first address byte give the start column. The low log2(PAGES) bits of the third address byte give the row. The second, fourth and fifth address bytes are ignored. Before any byte is loaded, every column of the page register holds 8'hFF.
- R3: Data cycles after the address store bytes at consecutive columns. Bytes arriving after the last column of the page are dropped; the pointer does not wrap.
- R4: Command 8'h10, given after at least one data byte has been loaded, holds `rb_n` low for exactly BUSY_CYC cycles starting at the clock edge that accepts it. Afterwards `rb_n` returns to 1 and status bit 6 reads 1.
- R5: A confirm given when no address sequence has completed, or when no data byte was loaded, is ignored and `rb_n` stays 1.
- R6: During a load, command 8'h85 followed by two address cycles moves the load pointer to the column given by the first of those two bytes. This can be repeated any number of times. Only the last jump before a byte decides where that byte goes.
- R7: While `rb_n` is 0, only 8'h70 and 8'hFF have any effect. Any other command byte, including 8'h80, neither shortens the busy interval nor starts a new load.
- R8: The status byte is {1'b0, ready, 5'b00000, fail}. `dout` shows it from the cycle after an accepted 8'h70 or a program start, until an accepted 8'h80, 8'h85 or 8'hFF. Unrecognised command bytes leave status mode as it is. Outside status mode `dout` is 8'h00.
- R9: At the end of programming, each array byte becomes old AND page. In addition, the STUCK_BITS of the cell at (STUCK_ROW, STUCK_COL) stay 1. The fail bit is set exactly when some bit that the page register holds at 0 is still 1 in the array. Page bits at 1 never cause a failure.
- R10: Command 8'hFF returns the block to idle, sets `rb_n` to 1, clears the load pointer and leaves status mode. If it arrives while busy, the array write and the fail update are skipped, and the fail bit keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cle | input | 1 | Command latch: the byte on `din` is a command |
| ale | input | 1 | Address latch: the byte on `din` is an address |
| we | input | 1 | Write strobe, one cycle per bus transfer |
| din | input | 8 | Bus byte written by the host |
| dout | output | 8 | Status byte in status mode, otherwise zero |
| rb_n | output | 1 | Ready (1) or busy (0) |

## Verification
The hardest case to reach from the ports is a failed program. No read path exists, so the only observable sign of where bytes landed is the fail bit. That bit rises only when a zero reaches the one defective cell. The bench sweeps a zero byte over every row and column, and it sweeps all 256 byte values into the defective cell. It also steers bytes toward that cell by sequential advance, through repeated column jumps, and by running past the page end. In each case a hit or a miss of that single cell shows whether addressing worked. An abort in the middle of the busy interval is placed after a passing program, so a skipped update shows up as an unchanged fail bit of 0.

// File: rtl/nand_pgm_if.sv
module nand_pgm_if #(
  parameter int COLS       = 16,
  parameter int PAGES      = 4,
  parameter int BUSY_CYC   = 8,
  parameter int STUCK_ROW  = 1,
  parameter int STUCK_COL  = 5,
  parameter logic [7:0] STUCK_BITS = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       rb_n
);
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int RW = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int BW = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_RCOL, S_BUSY} st_t;

  st_t          state;
  logic [2:0]   acnt;
  logic [CW:0]  ptr;
  logic [RW-1:0] row;
  logic         loaded, stat_mode, fail;
  logic [BW-1:0] bcnt;
  logic [7:0]   page [COLS];
  logic [7:0]   mem  [PAGES][COLS];
  logic [7:0]   merged [COLS];
  logic         pfail;

  wire busy   = (state == S_BUSY);
  wire cmd_wr = we & cle & ~ale;
  wire adr_wr = we & ale & ~cle;
  wire dat_wr = we & ~cle & ~ale;

  assign rb_n = ~busy;
  assign dout = stat_mode ? {1'b0, ~busy, 5'b00000, fail} : 8'h00;

  always_comb begin
    pfail = 1'b0;
    for (int c = 0; c < COLS; c++) begin
      merged[c] = mem[row][c] & page[c];
      if (int'(row) == STUCK_ROW && c == STUCK_COL) merged[c] = merged[c] | STUCK_BITS;
      pfail = pfail | (|(~page[c] & merged[c]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      acnt      <= '0;
      ptr       <= '0;
      row       <= '0;
      loaded    <= 1'b0;
      stat_mode <= 1'b0;
      fail      <= 1'b0;
      bcnt      <= '0;
      for (int c = 0; c < COLS; c++) page[c] <= 8'hFF;
      for (int r = 0; r < PAGES; r++)
        for (int c = 0; c < COLS; c++) mem[r][c] <= 8'hFF;
    end else if (busy) begin
      if (cmd_wr && din == 8'hFF) begin
        state     <= S_IDLE;
        ptr       <= '0;
        loaded    <= 1'b0;
        stat_mode <= 1'b0;
      end else begin
        if (cmd_wr && din == 8'h70) stat_mode <= 1'b1;
        if (bcnt == BW'(1)) begin
          state  <= S_IDLE;
          loaded <= 1'b0;
          fail   <= pfail;
          for (int c = 0; c < COLS; c++) mem[row][c] <= merged[c];
        end else begin
          bcnt <= bcnt - 1'b1;
        end
      end
    end else if (cmd_wr) begin
      case (din)
        8'h80: begin
          state     <= S_ADDR;
          acnt      <= '0;
          ptr       <= '0;
          loaded    <= 1'b0;
          stat_mode <= 1'b0;
          for (int c = 0; c < COLS; c++) page[c] <= 8'hFF;
        end
        8'h85: if (state == S_DATA) begin
          state     <= S_RCOL;
          acnt      <= '0;
          stat_mode <= 1'b0;
        end
        8'h10: if (state == S_DATA && loaded) begin
          state     <= S_BUSY;
          bcnt      <= BW'(BUSY_CYC);
          stat_mode <= 1'b1;
        end
        8'h70: stat_mode <= 1'b1;
        8'hFF: begin
          state     <= S_IDLE;
          ptr       <= '0;
          loaded    <= 1'b0;
          stat_mode <= 1'b0;
        end
        default: ;
      endcase
    end else if (adr_wr) begin
      if (state == S_ADDR) begin
        acnt <= acnt + 1'b1;
        if (acnt == 3'd0) ptr <= {1'b0, din[CW-1:0]};
        if (acnt == 3'd2) row <= din[RW-1:0];
        if (acnt == 3'd4) state <= S_DATA;
      end else if (state == S_RCOL) begin
        acnt <= acnt + 1'b1;
        if (acnt == 3'd0) ptr <= {1'b0, din[CW-1:0]};
        if (acnt == 3'd1) state <= S_DATA;
      end
    end else if (dat_wr && state == S_DATA && int'(ptr) < COLS) begin
      page[ptr[CW-1:0]] <= din;
      ptr    <= ptr + 1'b1;
      loaded <= 1'b1;
    end
  end
endmodule

// File: rtl/nand_pgm_if_chk.sv
module nand_pgm_if_chk #(
  parameter int BUSY_CYC = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cle,
  input logic       ale,
  input logic       we,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       rb_n
);
  logic [31:0] low_cnt;
  wire cmd_wr = we & cle & ~ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (rb_n) low_cnt <= '0;
    else low_cnt <= low_cnt + 1;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_n |-> low_cnt < 32'(BUSY_CYC)); // R4

  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_n && !$past(rb_n) && !$past(cmd_wr && din == 8'hFF)) |-> $past(low_cnt) == 32'(BUSY_CYC - 1)); // R4

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_n) |-> $past(cmd_wr && din == 8'h10)); // R5

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_n && low_cnt < 32'(BUSY_CYC - 1) && !(cmd_wr && din == 8'hFF)) |=> !rb_n); // R7

  AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && din == 8'hFF) |=> (rb_n && dout == 8'h00)); // R10

  AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_n) |-> (dout[7:1] == 7'b0000000)); // R8
endmodule

bind nand_pgm_if nand_pgm_if_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we(we),
  .din(din), .dout(dout), .rb_n(rb_n)
);

// File: tb/nand_pgm_if_test.sv
module nand_pgm_if_test;
  localparam int COLS = 16, PAGES = 4, BUSY_CYC = 8, STUCK_ROW = 1, STUCK_COL = 5;
  localparam logic [7:0] STUCK_BITS = 8'h11;

  logic clk = 0, rst_n = 0, cle = 0, ale = 0, we = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic rb_n;
  int total = 0, bad = 0;
  bit done = 0;

  nand_pgm_if #(.COLS(COLS), .PAGES(PAGES), .BUSY_CYC(BUSY_CYC), .STUCK_ROW(STUCK_ROW),
                .STUCK_COL(STUCK_COL), .STUCK_BITS(STUCK_BITS)) uut (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we(we),
    .din(din), .dout(dout), .rb_n(rb_n));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; we = 1; din = b;
    @(negedge clk);
    we = 0; cle = 0; ale = 0;
  endtask

  task automatic cmd(input logic [7:0] b); bus(1, 0, b); endtask
  task automatic adr(input logic [7:0] b); bus(0, 1, b); endtask
  task automatic dat(input logic [7:0] b); bus(0, 0, b); endtask

  task automatic start(input int r, input int c);
    cmd(8'h80); adr(8'(c)); adr(8'h3C); adr(8'(r)); adr(8'hA5); adr(8'h5A);
  endtask

  function automatic logic [7:0] st(input bit f);
    return {1'b0, 1'b1, 5'b00000, f};
  endfunction

  task automatic run_prog(input string req, input bit exp_fail);
    cmd(8'h10);
    chk(rb_n == 0, "R4", rb_n, 0);
    repeat (BUSY_CYC - 1) @(posedge clk);
    @(negedge clk);
    chk(rb_n == 0, "R4", rb_n, 0);
    @(posedge clk); @(negedge clk);
    chk(rb_n == 1, "R4", rb_n, 1);
    chk(dout == st(exp_fail), req, dout, st(exp_fail));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rb_n == 1, "R1", rb_n, 1);
    chk(dout == 8'h00, "R1", dout, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rb_n == 1 && dout == 8'h00, "R1", dout, 0);

    // R2 R9: zero byte swept over every row and column
    for (int r = 0; r < PAGES; r++)
      for (int c = 0; c < COLS; c++) begin
        start(r, c); dat(8'h00);
        run_prog("R2", (r == STUCK_ROW && c == STUCK_COL));
      end

    // R9: every byte value into the defective cell
    for (int d = 0; d < 256; d++) begin
      start(STUCK_ROW, STUCK_COL); dat(8'(d));
      run_prog("R9", ((~d & 32'(STUCK_BITS)) != 0));
    end

    // R3: sequential advance reaches the defective column
    start(STUCK_ROW, STUCK_COL - 2); dat(8'hFF); dat(8'hFF); dat(8'h00);
    run_prog("R3", 1);
    // R3: overflow past the last column must not wrap
    start(STUCK_ROW, COLS - 1);
    dat(8'hFF);
    for (int k = 0; k < STUCK_COL + 1; k++) dat(8'h00);
    run_prog("R3", 0);

    // R6: repeated jumps, last one lands on the defective column
    start(STUCK_ROW, 0); dat(8'hFF);
    cmd(8'h85); adr(8'd9); adr(8'h00); dat(8'hFF);
    cmd(8'h85); adr(8'(STUCK_COL)); adr(8'h00); dat(8'h00);
    run_prog("R6", 1);
    start(STUCK_ROW, 0); dat(8'hFF);
    cmd(8'h85); adr(8'(STUCK_COL)); adr(8'h00);
    cmd(8'h85); adr(8'(STUCK_COL + 1)); adr(8'h00); dat(8'h00);
    run_prog("R6", 0);

    // R5: confirm without data, and from idle
    start(STUCK_ROW, STUCK_COL); cmd(8'h10);
    chk(rb_n == 1, "R5", rb_n, 1);
    cmd(8'hFF); cmd(8'h10);
    chk(rb_n == 1, "R5", rb_n, 1);

    // R8: status mode entry, unknown byte keeps it, 0x80 leaves it
    cmd(8'h70);
    chk(dout == st(0), "R8", dout, st(0));
    cmd(8'h33);
    chk(dout == st(0), "R8", dout, st(0));
    cmd(8'h80);
    chk(dout == 8'h00, "R8", dout, 0);
    cmd(8'hFF);

    // R7: during busy, 0x80 ignored, 0x70 shows busy status
    start(0, 0); dat(8'h00);
    cmd(8'h10);
    cmd(8'h80);
    chk(rb_n == 0, "R7", rb_n, 0);
    cmd(8'h70);
    chk(dout == 8'h00 && rb_n == 0, "R7", dout, 0);
    repeat (BUSY_CYC) @(posedge clk);
    @(negedge clk);
    chk(dout == st(0), "R7", dout, st(0));
    dat(8'h00); cmd(8'h10);
    chk(rb_n == 1, "R7", rb_n, 1);

    // R10: abort mid-busy after a passing program keeps fail at 0
    start(STUCK_ROW, STUCK_COL); dat(8'h00);
    cmd(8'h10);
    @(negedge clk);
    cmd(8'hFF);
    chk(rb_n == 1 && dout == 8'h00, "R10", {rb_n, dout}, {1'b1, 8'h00});
    cmd(8'h70);
    chk(dout == st(0), "R10", dout, st(0));
    dat(8'h00); cmd(8'h10);
    chk(rb_n == 1, "R10", rb_n, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule